// File: doc/BRIEF.md
# PHY Control-Register Port Master

This block takes single register accesses from local logic and carries them out on the slow control-register port of a SerDes PHY. That port has no clock of its own, so every transfer is driven by pulses that the master generates. A requester presents an address, write data and a direction, and strobes start for one cycle. The block then runs the whole port transaction without further help. It issues an idle preamble, asserts select and drives the address. On a write it also drives the data. It then gives a one-pulse command strobe and clocks the port while it polls for the acknowledge.

The block ends each access with a one-cycle done pulse or a one-cycle timeout error pulse. On a successful read the captured data appears on `rdata_o`. The port clock rate is set by `HALF_PERIOD`, which counts system clocks per half period. `POLL_WAIT` sets the number of system clocks between the end of a port clock pulse and the sampling of the acknowledge. The preamble length and the poll limit are also parameters. Their defaults are 100 pulses and 10 polls.

Top module: `phy_cr_master`

## Requirements
- R1: While `rst_ni` is low and after its release, every port output (`cr_clk_o`, `cr_sel_o`, both enables, `cr_addr_o`, `cr_wdata_o`) is 0, `done_o` and `err_o` are 0 and `rdata_o` is 0.
- R2: Each port clock pulse is high for exactly `HALF_PERIOD` system cycles. No other port output changes while `cr_clk_o` is high. Within the preamble the low time between pulses is also `HALF_PERIOD` cycles.
- R3: Each access starts with exactly `PRE_PULSES` (default 100) complete port clock pulses. During these pulses select and both enables are 0.
- R4: After the preamble, select rises and stays high until the access ends. The latched address is on `cr_addr_o` before any enable rises.
- R5: On a write, the latched write data is on `cr_wdata_o` for at least one cycle before `cr_wr_en_o` rises.
- R6: The command strobe raises `cr_wr_en_o` for a write or `cr_rd_en_o` for a read, never both. It gives exactly one port clock pulse while the enable is high. The enable then falls and both enables are 0 afterwards.
- R7: The acknowledge is sampled `HALF_PERIOD + POLL_WAIT` cycles after each port clock falling edge that follows the strobe. Each low sample except the last allowed one is followed by exactly one more port clock pulse. If the acknowledge first reads high after k extra pulses (k < `POLL_LIMIT`), exactly k pulses follow the strobe.
- R8: If `POLL_LIMIT` (default 10) samples all read low, the access ends with `err_o` and no `done_o`. No pulse follows the last failed sample, so `POLL_LIMIT-1` pulses follow the strobe.
- R9: A read that completes captures `cr_rdata_i` at the sample that found the acknowledge high. `rdata_o` changes only in the cycle `done_o` is high, and keeps its value through writes and timed-out accesses.
- R10: `done_o` and `err_o` are single-cycle pulses, never high together. Either one rises `HALF_PERIOD + POLL_WAIT + 1` cycles after the last port clock falling edge. In that cycle select and both enables are already 0.
- R11: A start pulse that arrives while an access is in progress is ignored. That access produces exactly one completion, with its own address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request strobe, taken only when idle |
| write_i | input | 1 | Direction of the request: 1 write, 0 read |
| addr_i | input | ADDR_W | Register address of the request |
| wdata_i | input | DATA_W | Write data of the request |
| done_o | output | 1 | One-cycle pulse: access acknowledged |
| err_o | output | 1 | One-cycle pulse: acknowledge timeout |
| rdata_o | output | DATA_W | Data of the last completed read |
| cr_clk_o | output | 1 | Port clock, master generated |
| cr_sel_o | output | 1 | Port select |
| cr_rd_en_o | output | 1 | Port read enable |
| cr_wr_en_o | output | 1 | Port write enable |
| cr_addr_o | output | ADDR_W | Port address |
| cr_wdata_o | output | DATA_W | Port write data |
| cr_rdata_i | input | DATA_W | Port read data |
| cr_ack_i | input | 1 | Port acknowledge |

## Verification
The completion pulse is due `HALF_PERIOD + POLL_WAIT + 1` cycles after the last port clock falling edge. The bench counts falling-edge samples taken on the opposite system clock edge and compares that count against this sum. Pulse widths, the preamble count and the pulses after the strobe are tallied at each observed port clock edge. They are compared per access against values worked out from the acknowledge delay the bench model was given. That delay is swept from 0 to 11 pulses for both directions, which covers immediate acknowledge, the last allowed poll and timeout. The bench model changes acknowledge only on the opposite system clock edge. The design therefore always samples a settled value, one poll after each pulse.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW} cr_phase_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_ADDR, ST_DATA, ST_EN, ST_STROBE, ST_WAIT, ST_POLL
  } cr_state_e;

  function automatic logic pulsing(cr_state_e s);
    return (s == ST_PRE) || (s == ST_STROBE) || (s == ST_POLL);
  endfunction
endpackage

// File: rtl/cr_clk_gen.sv
module cr_clk_gen
  import cr_pkg::*;
#(
  parameter int HALF_PERIOD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic ready_o,
  output logic done_o,
  output logic cr_clk_o
);
  localparam int CW = $clog2(HALF_PERIOD + 1);
  localparam logic [CW-1:0] RELOAD = CW'(HALF_PERIOD - 1);

  cr_phase_e     ph_q;
  logic [CW-1:0] cnt_q;

  assign done_o  = (ph_q == PH_LOW) && (cnt_q == '0);
  assign ready_o = (ph_q == PH_IDLE) || done_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      cr_clk_o <= 1'b0;
    end else if (fire_i && ready_o) begin
      ph_q     <= PH_HIGH;
      cnt_q    <= RELOAD;
      cr_clk_o <= 1'b1;
    end else begin
      case (ph_q)
        PH_HIGH: begin
          if (cnt_q == '0) begin
            ph_q     <= PH_LOW;
            cnt_q    <= RELOAD;
            cr_clk_o <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_LOW: begin
          if (cnt_q == '0) ph_q <= PH_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cr_gap_timer.sv
module cr_gap_timer #(
  parameter int GAP = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic zero_o
);
  generate
    if (GAP == 0) begin : g_none
      logic unused_in;
      assign unused_in = clk_i ^ rst_ni ^ load_i;
      assign zero_o    = 1'b1;
    end else begin : g_cnt
      localparam int GW = $clog2(GAP + 1);
      logic [GW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             cnt_q <= '0;
        else if (load_i)         cnt_q <= GW'(GAP);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end
      assign zero_o = (cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/cr_seq.sv
module cr_seq
  import cr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int PRE_PULSES = 100,
  parameter int POLL_LIMIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              gen_ready_i,
  input  logic              gen_done_i,
  input  logic              gap_zero_i,
  output logic              gap_load_o,
  output logic              fire_o,
  output logic              sel_o,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int NP_W = $clog2(PRE_PULSES + 1);
  localparam int PL_W = $clog2(POLL_LIMIT + 1);
  localparam logic [PL_W-1:0] LAST_POLL = PL_W'(POLL_LIMIT - 1);

  cr_state_e         st_q;
  logic [NP_W-1:0]   npulse_q;
  logic [PL_W-1:0]   polls_q;
  logic              is_wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              pulse_end;

  assign fire_o     = pulsing(st_q) && (npulse_q != '0);
  assign pulse_end  = (npulse_q == '0) && gen_done_i;
  assign gap_load_o = ((st_q == ST_STROBE) || (st_q == ST_POLL)) && pulse_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      npulse_q <= '0;
      polls_q  <= '0;
      is_wr_q  <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      sel_o    <= 1'b0;
      rd_en_o  <= 1'b0;
      wr_en_o  <= 1'b0;
      addr_o   <= '0;
      wdata_o  <= '0;
      rdata_o  <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (fire_o && gen_ready_i) npulse_q <= npulse_q - 1'b1;
      case (st_q)
        ST_IDLE: if (start_i) begin
          is_wr_q  <= write_i;
          addr_q   <= addr_i;
          wdata_q  <= wdata_i;
          npulse_q <= NP_W'(PRE_PULSES);
          st_q     <= ST_PRE;
        end
        ST_PRE: if (pulse_end) begin
          sel_o <= 1'b1;
          st_q  <= ST_ADDR;
        end
        ST_ADDR: begin
          addr_o <= addr_q;
          st_q   <= is_wr_q ? ST_DATA : ST_EN;
        end
        ST_DATA: begin
          wdata_o <= wdata_q;
          st_q    <= ST_EN;
        end
        ST_EN: begin
          rd_en_o  <= !is_wr_q;
          wr_en_o  <= is_wr_q;
          npulse_q <= NP_W'(1);
          st_q     <= ST_STROBE;
        end
        ST_STROBE: if (pulse_end) begin
          rd_en_o <= 1'b0;
          wr_en_o <= 1'b0;
          polls_q <= '0;
          st_q    <= ST_WAIT;
        end
        ST_WAIT: if (gap_zero_i) begin
          if (ack_i || (polls_q == LAST_POLL)) begin
            if (ack_i && !is_wr_q) rdata_o <= rdata_i;
            done_o  <= ack_i;
            err_o   <= !ack_i;
            sel_o   <= 1'b0;
            addr_o  <= '0;
            wdata_o <= '0;
            st_q    <= ST_IDLE;
          end else begin
            polls_q  <= polls_q + 1'b1;
            npulse_q <= NP_W'(1);
            st_q     <= ST_POLL;
          end
        end
        ST_POLL: if (pulse_end) st_q <= ST_WAIT;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int HALF_PERIOD = 4,
  parameter int POLL_WAIT   = 16,
  parameter int PRE_PULSES  = 100,
  parameter int POLL_LIMIT  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cr_clk_o,
  output logic              cr_sel_o,
  output logic              cr_rd_en_o,
  output logic              cr_wr_en_o,
  output logic [ADDR_W-1:0] cr_addr_o,
  output logic [DATA_W-1:0] cr_wdata_o,
  input  logic [DATA_W-1:0] cr_rdata_i,
  input  logic              cr_ack_i
);
  logic fire, gen_ready, gen_done, gap_load, gap_zero;

  cr_clk_gen #(.HALF_PERIOD(HALF_PERIOD)) i_clk_gen (
    .clk_i, .rst_ni,
    .fire_i  (fire),
    .ready_o (gen_ready),
    .done_o  (gen_done),
    .cr_clk_o(cr_clk_o)
  );

  cr_gap_timer #(.GAP(POLL_WAIT)) i_gap (
    .clk_i, .rst_ni,
    .load_i(gap_load),
    .zero_o(gap_zero)
  );

  cr_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PRE_PULSES(PRE_PULSES), .POLL_LIMIT(POLL_LIMIT)
  ) i_seq (
    .clk_i, .rst_ni, .start_i, .write_i, .addr_i, .wdata_i,
    .ack_i      (cr_ack_i),
    .rdata_i    (cr_rdata_i),
    .gen_ready_i(gen_ready),
    .gen_done_i (gen_done),
    .gap_zero_i (gap_zero),
    .gap_load_o (gap_load),
    .fire_o     (fire),
    .sel_o      (cr_sel_o),
    .rd_en_o    (cr_rd_en_o),
    .wr_en_o    (cr_wr_en_o),
    .addr_o     (cr_addr_o),
    .wdata_o    (cr_wdata_o),
    .rdata_o    (rdata_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );
endmodule

// File: rtl/phy_cr_master_chk.sv
module phy_cr_master_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic              err_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              cr_clk_o,
  input logic              cr_sel_o,
  input logic              cr_rd_en_o,
  input logic              cr_wr_en_o,
  input logic [ADDR_W-1:0] cr_addr_o,
  input logic [DATA_W-1:0] cr_wdata_o
);
  a_r2_hold_while_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_clk_o && $past(cr_clk_o) |-> $stable(cr_sel_o) && $stable(cr_rd_en_o)
      && $stable(cr_wr_en_o) && $stable(cr_addr_o) && $stable(cr_wdata_o));

  a_r3_sel_rises_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cr_sel_o) |-> !cr_rd_en_o && !cr_wr_en_o);

  a_r4_en_under_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_rd_en_o || cr_wr_en_o) |-> cr_sel_o);

  a_r6_one_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cr_rd_en_o && cr_wr_en_o));

  a_r9_rdata_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> done_o);

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  a_r10_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  a_r10_port_quiet_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !cr_sel_o && !cr_rd_en_o && !cr_wr_en_o && !cr_clk_o);
endmodule

bind phy_cr_master phy_cr_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .done_o    (done_o),
  .err_o     (err_o),
  .rdata_o   (rdata_o),
  .cr_clk_o  (cr_clk_o),
  .cr_sel_o  (cr_sel_o),
  .cr_rd_en_o(cr_rd_en_o),
  .cr_wr_en_o(cr_wr_en_o),
  .cr_addr_o (cr_addr_o),
  .cr_wdata_o(cr_wdata_o)
);

// File: tb/test_phy_cr_master.sv
module test_phy_cr_master;
  localparam int HALF = 2;
  localparam int PW   = 3;
  localparam int PRE  = 100;
  localparam int LIM  = 10;
  localparam logic [15:0] RMASK = 16'h5A3C;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, write_i = 1'b0;
  logic [15:0] addr_i = '0, wdata_i = '0;
  logic        done_o, err_o, cr_clk_o, cr_sel_o, cr_rd_en_o, cr_wr_en_o;
  logic [15:0] rdata_o, cr_addr_o, cr_wdata_o, cr_rdata_i;
  logic        ack_r = 1'b0;

  assign cr_rdata_i = cr_addr_o ^ RMASK;

  phy_cr_master #(.HALF_PERIOD(HALF), .POLL_WAIT(PW), .PRE_PULSES(PRE), .POLL_LIMIT(LIM))
  i_phy_cr_master (
    .clk_i(clk), .rst_ni, .start_i, .write_i, .addr_i, .wdata_i,
    .done_o, .err_o, .rdata_o, .cr_clk_o, .cr_sel_o, .cr_rd_en_o, .cr_wr_en_o,
    .cr_addr_o, .cr_wdata_o, .cr_rdata_i, .cr_ack_i(ack_r)
  );

  int total = 0, bad = 0;

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // port monitor, sampled on the falling system edge
  logic        p_clk = 0, p_rd = 0, p_wr = 0, p_sel = 0;
  logic [15:0] p_addr = '0, p_wd = '0;
  int n_ack = 0, pre_rises = 0, pre_en = 0, en_pulses = 0, post_rises = 0, post_falls = 0;
  int hi_cnt = 0, lo_cnt = 0, since_fall = 0, stab_viol = 0, width_viol = 0;
  int done_cnt = 0, err_cnt = 0, end_since = 0, en_rises = 0, all_rises = 0, drop_viol = 0;
  bit strobe_done = 0, en_sel = 0, en_wr = 0;
  int en_pre = 0;
  logic [15:0] en_addr = '0, en_wd = '0, en_pwd = '0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (p_clk && !cr_clk_o) since_fall = 0; else since_fall++;
      if (!p_clk && cr_clk_o) begin
        all_rises++;
        if (!cr_sel_o) begin
          if (pre_rises > 0 && lo_cnt != HALF) width_viol++;
          pre_rises++;
          if (cr_rd_en_o || cr_wr_en_o) pre_en++;
        end
        if (cr_rd_en_o || cr_wr_en_o) en_pulses++;
        if (strobe_done) post_rises++;
        hi_cnt = 0;
      end
      if (p_clk && !cr_clk_o) begin
        if (hi_cnt != HALF) width_viol++;
        if (strobe_done) post_falls++;
        lo_cnt = 0;
      end
      if (cr_clk_o) begin
        hi_cnt++;
        if (p_clk && ({cr_sel_o, cr_rd_en_o, cr_wr_en_o, cr_addr_o, cr_wdata_o}
                      != {p_sel, p_rd, p_wr, p_addr, p_wd})) stab_viol++;
      end else lo_cnt++;
      if (!(p_rd || p_wr) && (cr_rd_en_o || cr_wr_en_o)) begin
        en_rises++;
        en_sel = cr_sel_o; en_addr = cr_addr_o; en_wd = cr_wdata_o; en_pwd = p_wd;
        en_wr = cr_wr_en_o; en_pre = pre_rises;
      end
      if ((p_rd || p_wr) && !(cr_rd_en_o && cr_wr_en_o) && !(cr_rd_en_o || cr_wr_en_o)) strobe_done = 1;
      if ((p_rd && !cr_rd_en_o && cr_wr_en_o) || (p_wr && !cr_wr_en_o && cr_rd_en_o)) drop_viol++;
      if (done_o) begin done_cnt++; end_since = since_fall; end
      if (err_o)  begin err_cnt++;  end_since = since_fall; end
      ack_r = strobe_done && (post_falls >= n_ack);
    end
    p_clk = cr_clk_o; p_rd = cr_rd_en_o; p_wr = cr_wr_en_o; p_sel = cr_sel_o;
    p_addr = cr_addr_o; p_wd = cr_wdata_o;
  end

  logic [15:0] last_rd = '0;

  task automatic run_access(bit wr, logic [15:0] a, logic [15:0] d, int n, bit inject);
    int guard = 0;
    int rises_at_end;
    int exp_post;
    @(posedge clk);
    n_ack = n; pre_rises = 0; pre_en = 0; en_pulses = 0; post_rises = 0; post_falls = 0;
    stab_viol = 0; width_viol = 0; done_cnt = 0; err_cnt = 0; end_since = -1;
    en_rises = 0; drop_viol = 0; strobe_done = 0; hi_cnt = 0; lo_cnt = 0;
    @(negedge clk);
    start_i = 1; write_i = wr; addr_i = a; wdata_i = d;
    @(negedge clk);
    start_i = 0; addr_i = 16'hFFFF; wdata_i = 16'h0;
    if (inject) begin
      repeat (20) @(negedge clk);
      start_i = 1; write_i = !wr; addr_i = ~a;
      @(negedge clk);
      start_i = 0;
    end
    while (done_cnt + err_cnt == 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(guard < 5000, "R10 completion seen", guard, 0);
    rises_at_end = all_rises;
    repeat (30) @(negedge clk);
    exp_post = (n < LIM) ? n : LIM - 1;
    check(pre_rises == PRE, "R3 preamble pulse count", pre_rises, PRE);
    check(pre_en == 0 && en_pre == PRE, "R3 preamble quiet", pre_en, 0);
    check(width_viol == 0, "R2 pulse widths", width_viol, 0);
    check(stab_viol == 0, "R2 outputs stable while clock high", stab_viol, 0);
    check(en_sel == 1'b1, "R4 select before enable", en_sel, 1);
    check(en_addr == a, "R4 address before enable", en_addr, a);
    if (wr) check(en_wd == d && en_pwd == d, "R5 write data ahead of enable", en_pwd, d);
    check(en_rises == 1 && en_wr == wr, "R6 enable kind", en_wr, wr);
    check(en_pulses == 1, "R6 single strobe pulse", en_pulses, 1);
    check(drop_viol == 0 && strobe_done, "R6 enables drop together", drop_viol, 0);
    check(post_rises == exp_post, (n < LIM) ? "R7 poll pulses" : "R8 pulses before timeout",
          post_rises, exp_post);
    if (n < LIM) check(done_cnt == 1 && err_cnt == 0, "R7 done on ack", done_cnt, 1);
    else         check(err_cnt == 1 && done_cnt == 0, "R8 timeout error", err_cnt, 1);
    check(end_since == HALF + PW + 1, "R10 completion latency", end_since, HALF + PW + 1);
    if (!wr && n < LIM) last_rd = a ^ RMASK;
    check(rdata_o == last_rd, "R9 read data", rdata_o, last_rd);
    check(done_cnt + err_cnt == 1 && all_rises == rises_at_end, "R11 one access only",
          done_cnt + err_cnt, 1);
    check({cr_clk_o, cr_sel_o, cr_rd_en_o, cr_wr_en_o, cr_addr_o, cr_wdata_o} == '0,
          "R10 port idle after access", cr_addr_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({done_o, err_o, rdata_o, cr_clk_o, cr_sel_o, cr_rd_en_o, cr_wr_en_o,
           cr_addr_o, cr_wdata_o} == '0, "R1 outputs in reset", 1, 0);
    rst_ni = 1;
    repeat (5) @(negedge clk);
    check({done_o, err_o, rdata_o, cr_clk_o, cr_sel_o, cr_rd_en_o, cr_wr_en_o,
           cr_addr_o, cr_wdata_o} == '0, "R1 outputs idle after reset", 1, 0);
    for (int w = 0; w < 2; w++) begin
      for (int n = 0; n <= LIM + 1; n++) begin
        logic [15:0] a = 16'h1000 + 16'(n * 16'h0111) + 16'(w);
        run_access(w[0], a, ~a ^ 16'(n), n, n == 3);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule